// File: doc/BRIEF.md
# Rotation-Aware Display Window Address Command Generator

This block produces the command bytes that set up scan orientation and the window start address of a 240x160 display memory. In that memory a page covers two pixel rows and a column is a single pixel column. A host raises one of two requests. An orientation request emits two bytes that fix the RAM address-increment order and the panel mirroring for the chosen rotation. A window request emits four bytes that place the write pointer at a start coordinate. The pointer's column and page axes trade places when the panel is turned by a quarter turn.

Bytes leave on a single valid/ready stream. Each byte carries a data/command flag, which is held low because every byte is a command. The rotation and the coordinates are captured when a request is accepted, and both request inputs are refused until the last byte of the current sequence has been taken. The rotation code is 0 for 0 degrees, 1 for 90, 2 for 180 and 3 for 270.

Top module: `wag_cmd_gen`

## Requirements
- R1: After reset `cmd_valid_o` is low and both `orient_ready_o` and `win_ready_o` are high.
- R2: An accepted orientation request emits two bytes. The first is the address-control byte 0x88 with bit 0 (wrap) set, bit 2 (negative increment) clear, and bit 1 (page-first) set only for codes 1 and 3. This gives 0x89 for codes 0 and 2 and 0x8B for codes 1 and 3.
- R3: The second orientation byte is 0xC0 with Y-mirror in bit 2, X-mirror in bit 1 and nibble order in bit 0, always 0. By code this gives 0xC2 for 0, 0xC0 for 1, 0xC4 for 2 and 0xC6 for 3.
- R4: An accepted window request emits four bytes in this order: 0x00|c[3:0], 0x10|c[7:4], 0x60|p[4:1], 0x70|((p>>5)&0xF). Here c is the column coordinate and p is the row coordinate.
- R5: For codes 0 and 2 the column is `xs_i` and the row is `ys_i`. For codes 1 and 3 the column is `ys_i` and the row is `xs_i`.
- R6: `cmd_dc_o` is low on every byte presented with `cmd_valid_o` high.
- R7: A request is accepted only when its ready output is high. Both readies stay low from the cycle after acceptance until the cycle after the final byte handshake. The first byte is presented in the cycle after acceptance.
- R8: While `cmd_valid_o` is high and `cmd_ready_i` is low, the next cycle keeps `cmd_valid_o` high and `cmd_byte_o` unchanged.
- R9: If both requests are raised in the same idle cycle, the orientation request is accepted and `win_ready_o` is low in that cycle.
- R10: `rot_i`, `xs_i` and `ys_i` are sampled only at acceptance. Changing them while a sequence is being sent does not alter its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rot_i | input | 2 | Rotation code, sampled at acceptance |
| xs_i | input | COORD_W | Window start x, sampled at acceptance |
| ys_i | input | COORD_W | Window start y, sampled at acceptance |
| orient_req_i | input | 1 | Orientation setup request |
| orient_ready_o | output | 1 | Orientation request can be accepted |
| win_req_i | input | 1 | Window address request |
| win_ready_o | output | 1 | Window request can be accepted |
| cmd_valid_o | output | 1 | Output byte valid |
| cmd_ready_i | input | 1 | Downstream takes the byte |
| cmd_byte_o | output | 8 | Command byte |
| cmd_dc_o | output | 1 | Data/command flag, low for commands |

## Verification
Two requests can arrive in the same cycle: an orientation request and a window request. The bench raises both together while the block is idle. Its reference model expects the orientation pair first, with `win_ready_o` low in that cycle, and then the four window bytes once the held window request is taken. Requests are also held high while a sequence is being sent, under random backpressure, with the rotation and coordinates scrambled after acceptance. Every cycle is compared against the queue of bytes the model predicted.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  typedef enum logic {
    SEQ_ORIENT = 1'b0,
    SEQ_WINDOW = 1'b1
  } seq_e;

  localparam logic [7:0] OP_COL_LO   = 8'h00;
  localparam logic [7:0] OP_COL_HI   = 8'h10;
  localparam logic [7:0] OP_PG_LO    = 8'h60;
  localparam logic [7:0] OP_PG_HI    = 8'h70;
  localparam logic [7:0] OP_ADDR_CTL = 8'h88;
  localparam logic [7:0] OP_MAP      = 8'hC0;

  localparam int ORIENT_LEN = 2;
  localparam int WINDOW_LEN = 4;
endpackage

// File: rtl/wag_orient_enc.sv
module wag_orient_enc
  import wag_pkg::*;
(
  input  rot_e       rot_i,
  output logic [7:0] ctl_o,
  output logic [7:0] map_o
);
  logic page_first, neg_inc, wrap;
  logic mirror_y, mirror_x, nib_order;

  always_comb begin
    page_first = rot_i[0];
    neg_inc    = 1'b0;
    wrap       = 1'b1;
    // Y mirror for the half-turn pair, X mirror where both code bits agree
    mirror_y   = rot_i[1];
    mirror_x   = ~(rot_i[0] ^ rot_i[1]);
    nib_order  = 1'b0;
    ctl_o = OP_ADDR_CTL | {5'd0, neg_inc, page_first, wrap};
    map_o = OP_MAP | {5'd0, mirror_y, mirror_x, nib_order};
  end
endmodule

// File: rtl/wag_addr_enc.sv
module wag_addr_enc
  import wag_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  rot_e                           rot_i,
  input  logic [COORD_W-1:0]             xs_i,
  input  logic [COORD_W-1:0]             ys_i,
  output logic [WINDOW_LEN-1:0][7:0]     bytes_o
);
  logic [COORD_W-1:0] col, row;
  logic [3:0] col_lo, col_hi, pg_lo, pg_hi;

  always_comb begin
    // quarter turns swap the axes
    col    = rot_i[0] ? ys_i : xs_i;
    row    = rot_i[0] ? xs_i : ys_i;
    col_lo = 4'(col);
    col_hi = 4'(col >> 4);
    pg_lo  = 4'(row >> 1);
    pg_hi  = 4'(row >> 5);
    bytes_o[0] = OP_COL_LO | {4'd0, col_lo};
    bytes_o[1] = OP_COL_HI | {4'd0, col_hi};
    bytes_o[2] = OP_PG_LO  | {4'd0, pg_lo};
    bytes_o[3] = OP_PG_HI  | {4'd0, pg_hi};
  end
endmodule

// File: rtl/wag_seq.sv
module wag_seq
  import wag_pkg::*;
#(
  localparam int IDX_W = $clog2(WINDOW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             orient_req_i,
  input  logic             win_req_i,
  input  logic             cmd_ready_i,
  output logic             orient_acc_o,
  output logic             win_acc_o,
  output logic             busy_o,
  output seq_e             kind_o,
  output logic [IDX_W-1:0] idx_o
);
  logic busy_q, last;
  seq_e kind_q;
  logic [IDX_W-1:0] idx_q;

  assign orient_acc_o = ~busy_q & orient_req_i;
  assign win_acc_o    = ~busy_q & win_req_i & ~orient_req_i;

  always_comb begin
    if (kind_q == SEQ_WINDOW) last = (idx_q == IDX_W'(WINDOW_LEN - 1));
    else                      last = (idx_q == IDX_W'(ORIENT_LEN - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= SEQ_ORIENT;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (orient_acc_o || win_acc_o) begin
        busy_q <= 1'b1;
        kind_q <= orient_acc_o ? SEQ_ORIENT : SEQ_WINDOW;
        idx_q  <= '0;
      end
    end else if (cmd_ready_i) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/wag_cmd_gen.sv
module wag_cmd_gen
  import wag_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         rot_i,
  input  logic [COORD_W-1:0] xs_i,
  input  logic [COORD_W-1:0] ys_i,
  input  logic               orient_req_i,
  output logic               orient_ready_o,
  input  logic               win_req_i,
  output logic               win_ready_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [7:0]         cmd_byte_o,
  output logic               cmd_dc_o
);
  localparam int IDX_W = $clog2(WINDOW_LEN);

  logic orient_acc, win_acc, busy;
  seq_e kind;
  logic [IDX_W-1:0] idx;
  rot_e rot_q;
  logic [COORD_W-1:0] xs_q, ys_q;
  logic [7:0] ctl_byte, map_byte;
  logic [WINDOW_LEN-1:0][7:0] win_bytes;

  wag_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .orient_req_i (orient_req_i),
    .win_req_i    (win_req_i),
    .cmd_ready_i  (cmd_ready_i),
    .orient_acc_o (orient_acc),
    .win_acc_o    (win_acc),
    .busy_o       (busy),
    .kind_o       (kind),
    .idx_o        (idx)
  );

  // operands captured at acceptance only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q <= ROT_0;
      xs_q  <= '0;
      ys_q  <= '0;
    end else if (orient_acc || win_acc) begin
      rot_q <= rot_e'(rot_i);
      xs_q  <= xs_i;
      ys_q  <= ys_i;
    end
  end

  wag_orient_enc u_orient (
    .rot_i (rot_q),
    .ctl_o (ctl_byte),
    .map_o (map_byte)
  );

  wag_addr_enc #(.COORD_W(COORD_W)) u_addr (
    .rot_i   (rot_q),
    .xs_i    (xs_q),
    .ys_i    (ys_q),
    .bytes_o (win_bytes)
  );

  always_comb begin
    if (kind == SEQ_WINDOW) cmd_byte_o = win_bytes[idx];
    else                    cmd_byte_o = idx[0] ? map_byte : ctl_byte;
  end

  assign cmd_valid_o    = busy;
  assign cmd_dc_o       = 1'b0;
  assign orient_ready_o = ~busy;
  assign win_ready_o    = ~busy & ~orient_req_i;
endmodule

// File: rtl/wag_cmd_gen_chk.sv
module wag_cmd_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       orient_req_i,
  input logic       orient_ready_o,
  input logic       win_req_i,
  input logic       win_ready_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [7:0] cmd_byte_o
);
  // R7
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (orient_req_i && orient_ready_o) || (win_req_i && win_ready_o)
    |=> cmd_valid_o && !orient_ready_o && !win_ready_o);

  // R8
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_byte_o));

  // R2
  orient_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orient_req_i && orient_ready_o |=> cmd_byte_o[7:2] == 6'b100010 && cmd_byte_o[0]);

  // R4
  win_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_i && win_ready_o |=> cmd_byte_o[7:4] == 4'h0);
endmodule

bind wag_cmd_gen wag_cmd_gen_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .orient_req_i   (orient_req_i),
  .orient_ready_o (orient_ready_o),
  .win_req_i      (win_req_i),
  .win_ready_o    (win_ready_o),
  .cmd_valid_o    (cmd_valid_o),
  .cmd_ready_i    (cmd_ready_i),
  .cmd_byte_o     (cmd_byte_o)
);

// File: tb/wag_cmd_gen_tb.sv
module wag_cmd_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rot = '0;
  logic [CW-1:0] xs = '0, ys = '0;
  logic orq = 1'b0, wrq = 1'b0, crdy = 1'b1;
  logic orient_ready, win_ready, cmd_valid, cmd_dc;
  logic [7:0] cmd_byte;

  int vec = 0, errs = 0, acc_cnt = 0;
  bit done = 1'b0, bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int unsigned exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wag_cmd_gen #(.COORD_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rot_i(rot), .xs_i(xs), .ys_i(ys),
    .orient_req_i(orq), .orient_ready_o(orient_ready),
    .win_req_i(wrq), .win_ready_o(win_ready),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(crdy),
    .cmd_byte_o(cmd_byte), .cmd_dc_o(cmd_dc)
  );

  task automatic push_orient(input int code);
    int deg;
    int unsigned ctl, mp;
    deg = code * 90;
    ctl = (deg == 90 || deg == 270) ? 'h8B : 'h89;
    case (deg)
      0:       mp = 'hC2;
      90:      mp = 'hC0;
      180:     mp = 'hC4;
      default: mp = 'hC6;
    endcase
    exp_q.push_back(ctl); tag_q.push_back("R2");
    exp_q.push_back(mp);  tag_q.push_back("R3");
  endtask

  task automatic push_window(input int code, input int x, input int y);
    int c, p;
    string t;
    if (code == 1 || code == 3) begin c = y; p = x; t = "R5"; end
    else begin c = x; p = y; t = "R4"; end
    exp_q.push_back(c % 16);                tag_q.push_back(t);
    exp_q.push_back(16 + (c / 16) % 16);    tag_q.push_back(t);
    exp_q.push_back(96 + (p / 2) % 16);     tag_q.push_back(t);
    exp_q.push_back(112 + (p / 32) % 16);   tag_q.push_back(t);
  endtask

  // reference model, updated on the same edge the design uses
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); tag_q.delete();
    end else if (exp_q.size() == 0) begin
      if (orq) begin push_orient(int'(rot)); acc_cnt++; end
      else if (wrq) begin push_window(int'(rot), int'(xs), int'(ys)); acc_cnt++; end
    end else if (crdy) begin
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  // compare every cycle (R8 covered: head byte must persist until popped)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, er, ew;
      vec++;
      ev = exp_q.size() != 0;
      er = !ev;
      ew = !ev && !orq;
      if (cmd_valid !== ev) begin
        errs++; $display("FAIL R7 cmd_valid act=%b exp=%b", cmd_valid, ev);
      end
      if (orient_ready !== er) begin
        errs++; $display("FAIL R7 orient_ready act=%b exp=%b", orient_ready, er);
      end
      if (win_ready !== ew) begin
        errs++; $display("FAIL R9 win_ready act=%b exp=%b", win_ready, ew);
      end
      if (ev) begin
        if (cmd_byte !== 8'(exp_q[0])) begin
          errs++; $display("FAIL %s cmd_byte act=%02h exp=%02h", tag_q[0], cmd_byte, 8'(exp_q[0]));
        end
        if (cmd_dc !== 1'b0) begin
          errs++; $display("FAIL R6 cmd_dc act=%b exp=0", cmd_dc);
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    crdy = bp ? lfsr[0] : 1'b1;
  end

  // R10: operands scrambled right after acceptance
  task automatic send(input bit o, input int code, input int x, input int y);
    int n;
    n = acc_cnt;
    rot = 2'(code); xs = CW'(x); ys = CW'(y);
    orq = o; wrq = !o;
    do begin @(posedge clk); #1; end while (acc_cnt == n);
    orq = 1'b0; wrq = 1'b0;
    rot = ~rot; xs = ~xs; ys = ys ^ 8'h5A;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    vec++;
    if (cmd_valid !== 1'b0 || orient_ready !== 1'b1 || win_ready !== 1'b1) begin
      errs++;
      $display("FAIL R1 reset state act=%b%b%b exp=011", cmd_valid, orient_ready, win_ready);
    end
    for (int pass = 0; pass < 2; pass++) begin
      bp = (pass == 1);
      for (int r = 0; r < 4; r++) send(1'b1, r, 0, 0);
      for (int r = 0; r < 4; r++) begin
        send(1'b0, r, 0, 0);
        send(1'b0, r, 239, 159);
        send(1'b0, r, 200, 101);
        send(1'b0, r, 17, 63);
      end
    end
    // R9: both requests in one idle cycle
    begin
      int n;
      while (exp_q.size() != 0) begin @(posedge clk); #1; end
      n = acc_cnt;
      rot = 2'd3; xs = 8'd90; ys = 8'd33;
      orq = 1'b1; wrq = 1'b1;
      do begin @(posedge clk); #1; end while (acc_cnt == n);
      orq = 1'b0;
      do begin @(posedge clk); #1; end while (acc_cnt == n + 1);
      wrq = 1'b0;
    end
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end
endmodule